// File: doc/BRIEF.md
# Delta-sigma converter serial output sequencer

This block is the device-side digital controller of a converter whose result leaves on a three-wire serial link: an active-low chip select, a serial clock driven by the reader, and a serial data line. It runs a fixed three-phase loop. First a conversion phase lasts a set number of system clocks. Then comes a low-power sleep phase. Last comes a data-output phase, after which a new conversion starts. The analog side is modelled by a cycle counter. When that counter expires, the parallel result input is captured into a static shift register. The captured value stays there for as long as the reader leaves chip select high.

Pulling chip select low while the block sleeps starts the output phase. The word is 24 bits, sent most significant first: four status bits, then twenty data bits. The first status bit is an end-of-conversion flag. If chip select is low during a conversion, the data line shows that flag as 1. It drops to 0 as soon as a fresh result is ready, so a reader can poll it. The data line moves only after falling serial-clock edges, so the reader samples on rising edges. Output ends on the 24th falling edge, or earlier if chip select rises. Either ending restarts conversion. Clocks after the word return ones. Chip select and serial clock are asynchronous to the system clock and pass through synchronizers.

The result input is a plain sampled level with no handshake. The reader's serial clock paces the output, so no back-pressure is needed. The output enable stands in for a tri-stated data pin.

Top module: `dsq_serial_seq`

## Requirements
- R1: Reset puts the block in the conversion phase with sleep_o low. The phases always follow the order conversion, sleep, output, conversion.
- R2: After reset is released, sleep_o rises exactly CONV_CYCLES system clocks later, provided chip select stays high.
- R3: While chip select is high in sleep, the block stays asleep with sleep_o high. The captured word is unchanged even if result_i changes.
- R4: sdo_oe_o is low whenever chip select has been high for longer than the synchronizer delay. It is high while chip select is low.
- R5: The output word is sent MSB first and is 24 bits: bit 23 is the end-of-conversion flag (0 = ready), bits 22..20 are 0, and bits 19..0 are the captured result.
- R6: sdo_o changes only after a falling serial-clock edge. It is stable through each high phase of the serial clock.
- R7: The 24th falling serial-clock edge ends the output phase and starts a conversion. Up to 8 further clock pulses each return a 1.
- R8: Chip select rising during the output phase aborts the word and starts a new conversion. The next word carries the new result.
- R9: With chip select low during a conversion, sdo_o is driven and reads 1. It falls to 0 when the conversion completes, and the word then follows without chip select toggling.
- R10: The word carries the value result_i had on the last cycle of the conversion just completed, with no pipeline latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock from the reader, asynchronous |
| result_i | input | DATA_W | Parallel conversion result, captured at end of conversion |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Drive enable for the data pin; low means high impedance |
| sleep_o | output | 1 | High only in the sleep phase |

## Verification
The checker looks at every cycle. It enforces the legal phase order, the held register during sleep, and shifting only on detected falling edges. It also checks the exit to conversion on the last bit or on an early chip-select rise, and a 0 flag while asleep. Some behaviour needs whole scenarios and the bench covers it. That includes the exact conversion length and the bit order and content of several result words. It also includes the trailing ones, a new result after an abort, polling of the end-of-conversion flag, and capture of a result changed late in a conversion.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_OUT   = 2'd2
  } dsq_state_e;
endpackage

// File: rtl/dsq_sync.sv
// Multi-stage level synchronizer for an asynchronous input.
module dsq_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (!rst_n) ff <= {STAGES{RST_VAL}};
    else        ff <= {ff[STAGES-2:0], din};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/dsq_conv_timer.sv
// Stand-in for the modulator: counts CYCLES clocks while run is high.
module dsq_conv_timer #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || done) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dsq_shifter.sv
// Static output register: parallel load, shift left with ones filling in.
module dsq_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '1;
    else if (load)  q <= din;
    else if (shift) q <= {q[W-2:0], 1'b1};
  end
endmodule

// File: rtl/dsq_serial_seq.sv
module dsq_serial_seq
  import dsq_pkg::*;
#(
  parameter int CONV_CYCLES = 1024,
  parameter int DATA_W      = 20,
  parameter int STAT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              sleep_o
);
  localparam int WORD_W = STAT_W + DATA_W;
  localparam int BCW    = $clog2(WORD_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(WORD_W - 1);
  // Ready status: leading end-of-conversion flag 0, remaining status bits 0.
  localparam logic [STAT_W-1:0] STAT_READY = '0;

  dsq_state_e        state, state_nx;
  logic              cs_q, sck_q, sck_qd, sck_fall;
  logic              conv_done, word_shift;
  logic [BCW-1:0]    bit_cnt;
  logic [WORD_W-1:0] word_q;

  dsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .din(cs_n_i), .q(cs_q)
  );

  dsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .din(sck_i), .q(sck_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sck_qd <= 1'b0;
    else        sck_qd <= sck_q;
  end
  assign sck_fall = sck_qd & ~sck_q;

  dsq_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_CONV), .done(conv_done)
  );

  assign word_shift = (state == ST_OUT) && sck_fall;

  dsq_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(conv_done),
    .din({STAT_READY, result_i}), .shift(word_shift), .q(word_q)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_CONV:  if (conv_done) state_nx = ST_SLEEP;
      ST_SLEEP: if (!cs_q)     state_nx = ST_OUT;
      ST_OUT: begin
        if (cs_q)                                state_nx = ST_CONV;
        else if (sck_fall && bit_cnt == LAST_BIT) state_nx = ST_CONV;
      end
      default:                 state_nx = ST_CONV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_CONV;
    else        state <= state_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || state != ST_OUT) bit_cnt <= '0;
    else if (sck_fall)             bit_cnt <= bit_cnt + 1'b1;
  end

  // During conversion the line shows a busy flag, which also supplies the
  // trailing ones after a complete word.
  assign sdo_o    = (state == ST_CONV) ? 1'b1 : word_q[WORD_W-1];
  assign sdo_oe_o = ~cs_q;
  assign sleep_o  = (state == ST_SLEEP);
endmodule

// File: rtl/dsq_serial_seq_chk.sv
module dsq_serial_seq_chk
  import dsq_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int BCW    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input dsq_state_e        state,
  input logic              cs_q,
  input logic              sck_fall,
  input logic [BCW-1:0]    bit_cnt,
  input logic [WORD_W-1:0] word_q,
  input logic              sdo_o,
  input logic              sleep_o
);
  localparam logic [BCW-1:0] LAST = BCW'(WORD_W - 1);

  assert_conv_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV) |=> (state == ST_CONV || state == ST_SLEEP));

  assert_sleep_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |=> (state == ST_SLEEP || state == ST_OUT));

  assert_sleep_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && cs_q) |=> (state == ST_SLEEP && $stable(word_q)));

  assert_eoc_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |-> !sdo_o);

  assert_shift_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUT && !sck_fall) |=> $stable(word_q));

  assert_word_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUT && !cs_q && sck_fall && bit_cnt == LAST)
      |=> (state == ST_CONV && sdo_o));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUT && cs_q) |=> (state == ST_CONV && !sleep_o));
endmodule

bind dsq_serial_seq dsq_serial_seq_chk #(.WORD_W(WORD_W), .BCW(BCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .cs_q(cs_q), .sck_fall(sck_fall),
  .bit_cnt(bit_cnt), .word_q(word_q), .sdo_o(sdo_o), .sleep_o(sleep_o)
);

// File: tb/test_dsq_serial_seq.sv
module test_dsq_serial_seq;
  localparam int CONV = 200;
  localparam int HALF = 6;

  typedef struct packed {
    logic [19:0] res;
    logic [23:0] exp;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{20'hABCDE, 24'h0ABCDE},
    '{20'h00000, 24'h000000},
    '{20'hFFFFF, 24'h0FFFFF},
    '{20'h5A5A5, 24'h05A5A5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic [19:0] result = '0;
  logic        sdo, sdo_oe, sleep;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dsq_serial_seq #(.CONV_CYCLES(CONV)) i_dsq_serial_seq (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .result_i(result),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sleep_o(sleep)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_sleep();
    int t = 0;
    while (!sleep && t < 2000) begin wclk(1); t++; end
    check(sleep, "R3 sleep reached", 32'(sleep), 32'd1);
  endtask

  // Reader: sample before each rise, confirm the bit holds over the high phase.
  task automatic shift_bits(input int n, output logic [31:0] bits);
    int bad = 0;
    logic b0, b1;
    bits = '0;
    for (int i = 0; i < n; i++) begin
      b0 = sdo;
      sck = 1'b1;
      wclk(HALF);
      b1 = sdo;
      if (b0 !== b1) bad++;
      bits = {bits[30:0], b0};
      sck = 1'b0;
      wclk(HALF);
    end
    check(bad == 0, "R6 stable while clock high", 32'(bad), 32'd0);
  endtask

  initial begin
    logic [31:0] bits;
    int n;
    result = VECS[0].res;
    wclk(4);
    // R1 / R4: reset state
    check(!sleep, "R1 reset sleep low", 32'(sleep), 32'd0);
    check(!sdo_oe, "R4 reset hi-z", 32'(sdo_oe), 32'd0);
    rst_n = 1'b1;
    n = 0;
    while (!sleep && n < 5000) begin wclk(1); n++; end
    check(n == CONV, "R2 conversion length", 32'(n), 32'(CONV));

    // Vector table: capture, hold in sleep, read out.
    for (int k = 0; k < 4; k++) begin
      if (k > 0) result = VECS[k].res;
      wait_sleep();
      result = ~VECS[k].res;
      wclk(50);
      check(sleep && !sdo_oe, "R3 hold asleep with cs high",
            {30'd0, sleep, sdo_oe}, 32'd2);
      cs_n = 1'b0;
      wclk(HALF);
      check(sdo_oe, "R4 drive with cs low", 32'(sdo_oe), 32'd1);
      shift_bits(24, bits);
      check(bits[23:0] == VECS[k].exp, "R5 word format", bits, 32'(VECS[k].exp));
      check(!sleep && sdo, "R7 converting after 24th fall",
            {30'd0, sleep, sdo}, 32'd1);
      cs_n = 1'b1;
      wclk(4);
      check(!sdo_oe, "R4 hi-z after cs high", 32'(sdo_oe), 32'd0);
    end

    // R7: 32-clock read, trailing ones.
    result = 20'h13579;
    wait_sleep();
    cs_n = 1'b0;
    wclk(HALF);
    shift_bits(32, bits);
    check(bits[31:8] == 24'h013579, "R7 word in 32-clock read", 32'(bits[31:8]), 32'h013579);
    check(bits[7:0] == 8'hFF, "R7 trailing ones", 32'(bits[7:0]), 32'hFF);
    cs_n = 1'b1;
    wclk(4);

    // R8: abort after 10 bits.
    result = 20'h2468A;
    wait_sleep();
    cs_n = 1'b0;
    wclk(HALF);
    shift_bits(10, bits);
    check(bits[9:0] == 10'(24'h02468A >> 14), "R8 partial prefix",
          32'(bits[9:0]), 32'(24'h02468A >> 14));
    cs_n = 1'b1;
    wclk(4);
    check(!sleep, "R8 conversion after abort", 32'(sleep), 32'd0);
    result = 20'h0F0F0;
    n = 0;
    while (!sleep && n < 5000) begin wclk(1); n++; end
    check(n > CONV - 10 && n <= CONV, "R8 fresh conversion length", 32'(n), 32'(CONV));
    cs_n = 1'b0;
    wclk(HALF);
    shift_bits(24, bits);
    check(bits[23:0] == 24'h00F0F0, "R8 new result after abort", bits, 32'h00F0F0);

    // R9 / R10: keep cs low, poll the busy flag, change result late.
    check(sdo_oe && sdo, "R9 busy flag reads 1", {30'd0, sdo_oe, sdo}, 32'd3);
    result = 20'h11111;
    wclk(150);
    check(sdo, "R9 still busy mid-conversion", 32'(sdo), 32'd1);
    result = 20'hC3C3C;
    n = 0;
    while (sdo && n < 2000) begin wclk(1); n++; end
    check(!sdo, "R9 flag falls at completion", 32'(sdo), 32'd0);
    wclk(HALF);
    shift_bits(24, bits);
    check(bits[23:0] == 24'h0C3C3C, "R10 latest result captured", bits, 32'h0C3C3C);
    cs_n = 1'b1;
    wclk(4);
    check(!sdo_oe, "R4 final hi-z", 32'(sdo_oe), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule